// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation tree held in memory. A request carries the virtual address, whether the access is a write, and whether it comes from user or kernel mode. The walker reads the first-level (directory) entry and then the second-level (table) entry through a single 32-bit read port with a valid/ready handshake. It applies the present and permission checks at each level and ends the walk as soon as one of them fails.

Each walk ends with a response lasting one cycle. On success the response gives the physical address and the final entry. On failure it gives a fault with a cause code, the faulting virtual address and the access attributes of the request. Only one walk is in progress at any time, and a new request is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to the base with its low 12 bits cleared plus four times virtual address bits 31:22. The second read goes to the directory entry's bits 31:12 with the low 12 bits cleared, plus four times virtual address bits 21:12.
- R2: On success the physical address is the final entry's bits 31:12 followed by virtual address bits 11:0, and the response entry output holds the full final entry, including any bits the walker does not use.
- R3: An entry with bit 0 (present) clear causes a fault with cause 0. A directory entry that is not present ends the walk after one read.
- R4: A user request (user input 1) faults with cause 1 unless bit 2 (user) is set in both the directory entry and the table entry. If the directory entry fails this check, the walk ends after one read.
- R5: A user write faults with cause 1 unless bit 1 (writable) is set in both entries.
- R6: A kernel request ignores the user and writable bits, so it never gets a cause 1 fault.
- R7: Every response returns the request's virtual address, write flag and user flag.
- R8: The request ready output is high only in idle. A request presented during a walk is ignored and gives no extra walk or response.
- R9: While a memory read is waiting for ready, its address stays unchanged and valid stays high.
- R10: Synchronous active-high reset, including in the middle of a walk, returns the walker to idle with no memory read and no response pending.
- R11: The response valid output is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Physical address of the directory, captured when a request is accepted |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| mem_valid_o | output | 1 | Memory read request |
| mem_ready_i | input | 1 | Memory read completes this cycle |
| mem_addr_o | output | 32 | Memory read word address |
| mem_rdata_i | input | 32 | Read data, valid when valid and ready are both high |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_fault_o | output | 1 | 1 = page fault |
| rsp_cause_o | output | 1 | Fault cause: 0 not present, 1 protection |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_pte_o | output | 32 | Last entry read |
| rsp_vaddr_o | output | 32 | Virtual address of the request |
| rsp_write_o | output | 1 | Write flag of the request |
| rsp_user_o | output | 1 | User flag of the request |

## Verification
The main vectors cover every combination of user or kernel mode and read or write against entries that lack the user bit, the writable bit or the present bit, with the missing bit placed in the directory entry in some cases and in the table entry in others. This shows whether permissions are combined across both levels and whether a fault ends the walk after the first read or after the second. Some vectors add memory stall cycles, which separates correct handshake holding from a walker that assumes immediate data. Table indices 0 and 1023 and an unaligned base check the address arithmetic at its limits.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIR  = 2'd1,
        ST_TBL  = 2'd2,
        ST_RESP = 2'd3
    } walk_st_e;

    typedef enum logic {
        CAUSE_NOTPRESENT = 1'b0,
        CAUSE_PROTECT    = 1'b1
    } fault_cause_e;

    localparam int unsigned BIT_PRESENT = 0;
    localparam int unsigned BIT_WRITE   = 1;
    localparam int unsigned BIT_USER    = 2;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned ENT_SH = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] dir_entry,
    input  logic [ADDR_W-1:0] leaf_entry,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [ADDR_W-1:0] paddr
);
    localparam int unsigned DIR_LO = OFF_W + IDX_W;
    localparam int unsigned TBL_LO = OFF_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    always_comb begin
        dir_idx  = vaddr[DIR_LO +: IDX_W];
        tbl_idx  = vaddr[TBL_LO +: IDX_W];
        dir_addr = {base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                 + ADDR_W'({dir_idx, {ENT_SH{1'b0}}});
        tbl_addr = {dir_entry[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                 + ADDR_W'({tbl_idx, {ENT_SH{1'b0}}});
        paddr    = {leaf_entry[ADDR_W-1:OFF_W], vaddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/pw_perm.sv
module pw_perm
    import pw_pkg::*;
#(
    parameter int unsigned ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    input  logic             acc_w_in,
    input  logic             acc_u_in,
    output logic             acc_w_out,
    output logic             acc_u_out,
    output logic             fault,
    output fault_cause_e     cause
);
    logic present;
    logic prot;

    always_comb begin
        present   = entry[BIT_PRESENT];
        acc_w_out = acc_w_in & entry[BIT_WRITE];
        acc_u_out = acc_u_in & entry[BIT_USER];
        prot      = is_user && (!acc_u_out || (is_write && !acc_w_out));
        fault     = !present || prot;
        cause     = !present ? CAUSE_NOTPRESENT : CAUSE_PROTECT;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_vaddr_i,
    input  logic              req_write_i,
    input  logic              req_user_i,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_fault_o,
    output logic              rsp_cause_o,
    output logic [ADDR_W-1:0] rsp_paddr_o,
    output logic [ADDR_W-1:0] rsp_pte_o,
    output logic [ADDR_W-1:0] rsp_vaddr_o,
    output logic              rsp_write_o,
    output logic              rsp_user_o
);
    localparam int unsigned ENT_SH = $clog2(ADDR_W / 8);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] vaddr;
        logic              wr;
        logic              usr;
        logic              acc_w;
        logic              acc_u;
        logic [ADDR_W-1:0] pde;
        logic [ADDR_W-1:0] pte;
        logic              fault;
        fault_cause_e      cause;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [ADDR_W-1:0] dir_addr, tbl_addr, paddr;
    logic              chk_acc_w, chk_acc_u, chk_fault;
    logic              lvl_w_in, lvl_u_in;
    fault_cause_e      chk_cause;

    pw_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)
    ) u_addr (
        .base      (q.base),
        .vaddr     (q.vaddr),
        .dir_entry (q.pde),
        .leaf_entry(q.pte),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr),
        .paddr     (paddr)
    );

    // Directory level starts from full permission; table level inherits it.
    assign lvl_w_in = (q.st == ST_DIR) ? 1'b1 : q.acc_w;
    assign lvl_u_in = (q.st == ST_DIR) ? 1'b1 : q.acc_u;

    pw_perm #(.ENT_W(ADDR_W)) u_perm (
        .entry    (mem_rdata_i),
        .is_write (q.wr),
        .is_user  (q.usr),
        .acc_w_in (lvl_w_in),
        .acc_u_in (lvl_u_in),
        .acc_w_out(chk_acc_w),
        .acc_u_out(chk_acc_u),
        .fault    (chk_fault),
        .cause    (chk_cause)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.st    = ST_DIR;
                    d.base  = base_i;
                    d.vaddr = req_vaddr_i;
                    d.wr    = req_write_i;
                    d.usr   = req_user_i;
                    d.acc_w = 1'b1;
                    d.acc_u = 1'b1;
                    d.fault = 1'b0;
                    d.cause = CAUSE_NOTPRESENT;
                end
            end
            ST_DIR: begin
                if (mem_ready_i) begin
                    d.pde   = mem_rdata_i;
                    d.acc_w = chk_acc_w;
                    d.acc_u = chk_acc_u;
                    if (chk_fault) begin
                        d.pte   = mem_rdata_i;
                        d.fault = 1'b1;
                        d.cause = chk_cause;
                        d.st    = ST_RESP;
                    end else begin
                        d.st    = ST_TBL;
                    end
                end
            end
            ST_TBL: begin
                if (mem_ready_i) begin
                    d.pte   = mem_rdata_i;
                    d.fault = chk_fault;
                    d.cause = chk_cause;
                    d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign req_ready_o = (q.st == ST_IDLE);
    assign mem_valid_o = (q.st == ST_DIR) || (q.st == ST_TBL);
    assign mem_addr_o  = (q.st == ST_TBL) ? tbl_addr : dir_addr;
    assign rsp_valid_o = (q.st == ST_RESP);
    assign rsp_fault_o = q.fault;
    assign rsp_cause_o = q.cause;
    assign rsp_paddr_o = q.fault ? '0 : paddr;
    assign rsp_pte_o   = q.pte;
    assign rsp_vaddr_o = q.vaddr;
    assign rsp_write_o = q.wr;
    assign rsp_user_o  = q.usr;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready_o,
    input logic              mem_valid_o,
    input logic              mem_ready_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              rsp_valid_o,
    input logic              rsp_fault_o,
    input logic              rsp_cause_o,
    input logic [ADDR_W-1:0] rsp_paddr_o,
    input logic [ADDR_W-1:0] rsp_pte_o,
    input logic [ADDR_W-1:0] rsp_vaddr_o,
    input logic              rsp_write_o,
    input logic              rsp_user_o
);
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

    assert_idle_only_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> (!mem_valid_o && !rsp_valid_o));

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_fault_o) |->
            (rsp_paddr_o[OFF_W-1:0] == rsp_vaddr_o[OFF_W-1:0]
             && rsp_paddr_o[ADDR_W-1:OFF_W] == rsp_pte_o[ADDR_W-1:OFF_W]));

    assert_ok_present_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_fault_o) |-> rsp_pte_o[0]);

    assert_user_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_fault_o && rsp_user_o) |-> rsp_pte_o[2]);

    assert_user_write_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_fault_o && rsp_user_o && rsp_write_o) |-> rsp_pte_o[1]);

    assert_kernel_noprot_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_fault_o && !rsp_user_o) |-> !rsp_cause_o);

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (req_ready_o && !mem_valid_o && !rsp_valid_o));
endmodule

bind pt_walker pw_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready_o(req_ready_o),
    .mem_valid_o(mem_valid_o),
    .mem_ready_i(mem_ready_i),
    .mem_addr_o (mem_addr_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_fault_o(rsp_fault_o),
    .rsp_cause_o(rsp_cause_o),
    .rsp_paddr_o(rsp_paddr_o),
    .rsp_pte_o  (rsp_pte_o),
    .rsp_vaddr_o(rsp_vaddr_o),
    .rsp_write_o(rsp_write_o),
    .rsp_user_o (rsp_user_o)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base = 32'h0001_0ABC;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_valid;
    logic        mem_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        rsp_valid, rsp_fault, rsp_cause, rsp_write, rsp_user;
    logic [31:0] rsp_paddr, rsp_pte, rsp_vaddr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst), .base_i(base),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_vaddr_i(req_vaddr), .req_write_i(req_write), .req_user_i(req_user),
        .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
        .rsp_paddr_o(rsp_paddr), .rsp_pte_o(rsp_pte), .rsp_vaddr_o(rsp_vaddr),
        .rsp_write_o(rsp_write), .rsp_user_o(rsp_user)
    );

    // Memory model: sparse words, unmapped reads return zero (not present).
    logic [31:0] pmem [int unsigned];
    int          stall_cfg = 0;
    int          wait_cnt  = 0;
    int          nreads    = 0;
    int          nrsp      = 0;
    logic [31:0] rd_log [2];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    assign mem_rdata = mem_rd(mem_addr);
    assign mem_ready = (wait_cnt >= stall_cfg);

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (nreads < 2) rd_log[nreads] <= mem_addr;
            nreads   <= nreads + 1;
            wait_cnt <= 0;
        end else if (mem_valid) begin
            wait_cnt <= wait_cnt + 1;
        end
        if (rsp_valid) nrsp <= nrsp + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        us;
        logic        flt;
        logic        cause;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0123, 1'b0, 1'b1, 1'b0, 1'b0, 32'hABCD_E123, 2'd2, 2'd0},
        '{32'h0040_0123, 1'b1, 1'b1, 1'b0, 1'b0, 32'hABCD_E123, 2'd2, 2'd2},
        '{32'h0040_1FFF, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0,         2'd2, 2'd0},
        '{32'h0040_1FFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5FFF, 2'd2, 2'd1},
        '{32'h0040_2000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0,         2'd2, 2'd0},
        '{32'h0040_2000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5555_5000, 2'd2, 2'd0},
        '{32'h0040_3456, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'd2, 2'd1},
        '{32'h0100_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'd1, 2'd0},
        '{32'h0080_5ABC, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0,         2'd1, 2'd0},
        '{32'h0080_5ABC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1111_1ABC, 2'd2, 2'd0},
        '{32'h00C0_6010, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0,         2'd1, 2'd2},
        '{32'h00C0_6010, 1'b0, 1'b1, 1'b0, 1'b0, 32'h2222_2010, 2'd2, 2'd0},
        '{32'h00C0_6010, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2222_2010, 2'd2, 2'd3},
        '{32'h007F_F001, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_F001, 2'd2, 2'd0},
        '{32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'd1, 2'd0}
    };

    logic [31:0] g_paddr, g_pte, g_vaddr;
    logic        g_fault, g_cause, g_write, g_user, g_after;

    task automatic walk(input logic [31:0] va, input logic wr, input logic us);
        int guard;
        @(negedge clk);
        nreads    = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_user  = us;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        g_paddr = rsp_paddr; g_pte   = rsp_pte;   g_vaddr = rsp_vaddr;
        g_fault = rsp_fault; g_cause = rsp_cause;
        g_write = rsp_write; g_user  = rsp_user;
        @(negedge clk);
        g_after = rsp_valid;
    endtask

    initial begin
        pmem[32'h0001_0004] = 32'h0002_0007;
        pmem[32'h0001_0008] = 32'h0003_0003;
        pmem[32'h0001_000C] = 32'h0004_0005;
        pmem[32'h0001_0010] = 32'h0000_0006;
        pmem[32'h0002_0000] = 32'hABCD_EE07;
        pmem[32'h0002_0004] = 32'h1234_5005;
        pmem[32'h0002_0008] = 32'h5555_5003;
        pmem[32'h0002_000C] = 32'h7777_7006;
        pmem[32'h0002_0FFC] = 32'hFFFF_F007;
        pmem[32'h0003_0014] = 32'h1111_1007;
        pmem[32'h0004_0018] = 32'h2222_2007;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R10 no read after reset", {31'b0, mem_valid}, 32'd0);
        chk("R10 no response after reset", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] dira, tbla;
            stall_cfg = int'(VECS[i].stall);
            walk(VECS[i].va, VECS[i].wr, VECS[i].us);
            dira = 32'h0001_0000 + {20'b0, VECS[i].va[31:22], 2'b00};
            tbla = {mem_rd(dira)[31:12], 12'h0} + {20'b0, VECS[i].va[21:12], 2'b00};
            chk("R1 directory address", rd_log[0], dira);
            chk("R3 R4 read count", nreads, {30'b0, VECS[i].nrd});
            if (VECS[i].nrd == 2'd2) chk("R1 table address", rd_log[1], tbla);
            chk("R3 R4 R5 R6 fault", {31'b0, g_fault}, {31'b0, VECS[i].flt});
            if (VECS[i].flt) begin
                chk("R3 R4 R5 cause", {31'b0, g_cause}, {31'b0, VECS[i].cause});
                chk("R7 fault write flag", {31'b0, g_write}, {31'b0, VECS[i].wr});
                chk("R7 fault user flag", {31'b0, g_user}, {31'b0, VECS[i].us});
            end else begin
                chk("R2 physical address", g_paddr, VECS[i].pa);
                chk("R2 final entry", g_pte, mem_rd(tbla));
            end
            chk("R7 vaddr returned", g_vaddr, VECS[i].va);
            chk("R11 response one cycle", {31'b0, g_after}, 32'd0);
        end

        // R8: request held during a walk is ignored
        stall_cfg = 3;
        @(negedge clk);
        nrsp = 0;
        nreads = 0;
        req_valid = 1'b1; req_vaddr = 32'h0040_0123; req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_vaddr = 32'h0080_5ABC;
        chk("R8 ready low during walk", {31'b0, req_ready}, 32'd0);
        while (!rsp_valid) @(negedge clk);
        req_valid = 1'b0;
        chk("R8 first request kept", rsp_vaddr, 32'h0040_0123);
        chk("R8 physical address", rsp_paddr, 32'hABCD_E123);
        repeat (6) @(negedge clk);
        chk("R8 single response", nrsp, 32'd1);
        chk("R8 no extra reads", nreads, 32'd2);

        // R10: reset in the middle of a walk
        stall_cfg = 5;
        nrsp = 0;
        req_valid = 1'b1; req_vaddr = 32'h00C0_6010;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 read pending under stall", {31'b0, mem_valid}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 idle after mid-walk reset", {31'b0, req_ready}, 32'd1);
        chk("R10 read dropped", {31'b0, mem_valid}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R10 no response after reset", nrsp, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule